// File: doc/BRIEF.md
# Multiprocessor interrupt pending register file

This block holds the interrupt pending state of a small multiprocessor and exposes it as memory-mapped registers on a simple 32-bit read/write bus. Each processor owns one 4096-byte page. In that page software reads the processor's pending word and changes it through two write-only words. One word sets bits and the other clears them, and both act only on the bits written as one. Processors use these words to send interrupts to each other.

A master page follows the last processor page. It collects device interrupt requests, which are latched on their rising edge, into a master pending word. It also holds an enable mask with a global enable bit, and a readable and writable target register. The target register names the processor that receives undirected interrupts. Each processor has one interrupt request output. The output is high while the processor's own page has a pending bit, or while the processor is the target and an enabled master interrupt is pending under the global enable.

Top module: `irq_pending_rf`

## Requirements
- R1: While reset is asserted every processor pending word, the master pending word, the mask and the target register are zero. All `cpu_irq` bits are low and `bus_rdata` is zero.
- R2: Processor bank n occupies the page starting at byte address n*4096, and its pending word is read at offset 0x0. Read data appears on `bus_rdata` in the cycle after the cycle with `bus_rd` high, and `bus_rdata` is zero in the cycle after any cycle without a read.
- R3: A write to offset 0x8 of processor bank n sets every pending bit of bank n whose write-data bit is one. Bits written as zero keep their value.
- R4: A write to offset 0x4 of processor bank n clears every pending bit of bank n whose write-data bit is one. Bits written as zero keep their value.
- R5: When a set request and a clear request for the same master pending bit take effect on the same clock edge, the bit ends up set.
- R6: The master bank starts at byte address NCPUS*4096. Its words are: pending (read-only) at 0x0, mask at 0x4, clear at 0x8, set at 0xC, and target at 0x10. The mask and target words are readable and writable.
- R7: Reads of write-only words and of addresses with no register return zero. Writes to such addresses, and to any pending word, change no state.
- R8: `cpu_irq[n]` is high in every cycle in which processor bank n has a pending bit.
- R9: Master requests are gated by the mask. Mask bit 31 is the global enable. Mask bit i (0 to 30) enables master pending bit i, so bit 7 enables level 14 and bit 19 enables level 10. Master pending bit 31 never requests. When the global enable is one and an enabled master bit is pending, the target processor's `cpu_irq` is high. Otherwise the master bank raises no `cpu_irq`.
- R10: The target register stores the low 8 bits written and reads them back. A stored value of NCPUS or higher steers master requests to processor 0.
- R11: A `dev_irq[i]` input that is sampled high after being sampled low on the previous edge sets master pending bit i on that edge. A level held high does not set the bit again after it is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| dev_irq | input | 32 | Device interrupt request levels, one per master pending bit |
| cpu_irq | output | NCPUS | Interrupt request to each processor |

## Verification
Every state change from a bus write or a device edge is due on the first clock edge after the cycle that presents it. `cpu_irq` follows that state with no further delay, so the bench reads it at the falling edge right after the write cycle. Read data is registered once, so each read is checked at the falling edge after the read cycle, and `bus_rdata` must be zero again one cycle later. A behavioural model steps on the same rising edges as the design, and its `cpu_irq` and `bus_rdata` are compared at every falling edge. The design needs two extra edges after reset release, so the bench holds all inputs idle for longer than that.

// File: rtl/irq_rf_pkg.sv
package irq_rf_pkg;

  localparam int DATA_W        = 32;
  localparam int PAGE_SHIFT    = 12;
  localparam int GLOBAL_EN_BIT = 31;

  // processor page word offsets
  localparam logic [PAGE_SHIFT-1:0] OFF_CPU_PEND = 12'h000;
  localparam logic [PAGE_SHIFT-1:0] OFF_CPU_CLR  = 12'h004;
  localparam logic [PAGE_SHIFT-1:0] OFF_CPU_SET  = 12'h008;

  // master page word offsets
  localparam logic [PAGE_SHIFT-1:0] OFF_M_PEND   = 12'h000;
  localparam logic [PAGE_SHIFT-1:0] OFF_M_MASK   = 12'h004;
  localparam logic [PAGE_SHIFT-1:0] OFF_M_CLR    = 12'h008;
  localparam logic [PAGE_SHIFT-1:0] OFF_M_SET    = 12'h00C;
  localparam logic [PAGE_SHIFT-1:0] OFF_M_TGT    = 12'h010;

  typedef enum logic [3:0] {
    REG_NONE     = 4'd0,
    REG_CPU_PEND = 4'd1,
    REG_CPU_CLR  = 4'd2,
    REG_CPU_SET  = 4'd3,
    REG_M_PEND   = 4'd4,
    REG_M_MASK   = 4'd5,
    REG_M_CLR    = 4'd6,
    REG_M_SET    = 4'd7,
    REG_M_TGT    = 4'd8
  } reg_sel_e;

endpackage

// File: rtl/irq_rf_decode.sv
module irq_rf_decode
  import irq_rf_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NCPUS     = 4,
  parameter int CPU_IDX_W = 2
) (
  input  logic [ADDR_W-1:0]    addr,
  output reg_sel_e             sel,
  output logic [CPU_IDX_W-1:0] cpu_idx
);

  localparam int PG_W = ADDR_W - PAGE_SHIFT;

  logic [PG_W-1:0]       page;
  logic [PAGE_SHIFT-1:0] off;
  logic                  in_cpu;
  logic                  in_master;

  assign page      = addr[ADDR_W-1:PAGE_SHIFT];
  assign off       = addr[PAGE_SHIFT-1:0];
  assign in_cpu    = (page < PG_W'(NCPUS));
  assign in_master = (page == PG_W'(NCPUS));
  assign cpu_idx   = in_cpu ? page[CPU_IDX_W-1:0] : '0;

  always_comb begin
    sel = REG_NONE;
    if (in_cpu) begin
      case (off)
        OFF_CPU_PEND: sel = REG_CPU_PEND;
        OFF_CPU_CLR:  sel = REG_CPU_CLR;
        OFF_CPU_SET:  sel = REG_CPU_SET;
        default:      sel = REG_NONE;
      endcase
    end else if (in_master) begin
      case (off)
        OFF_M_PEND: sel = REG_M_PEND;
        OFF_M_MASK: sel = REG_M_MASK;
        OFF_M_CLR:  sel = REG_M_CLR;
        OFF_M_SET:  sel = REG_M_SET;
        OFF_M_TGT:  sel = REG_M_TGT;
        default:    sel = REG_NONE;
      endcase
    end
  end

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] pend
);

  logic [W-1:0] pend_q;
  logic [W-1:0] pend_d;
  logic         pend_en;

  // set has priority over clear on the same bit
  always_comb begin
    pend_d  = (pend_q & ~clr_vec) | set_vec;
    pend_en = |(set_vec | clr_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/irq_dev_edge.sv
module irq_dev_edge #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);

  logic [W-1:0] prev_q;

  assign rise = lvl & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= lvl;
    end
  end

endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_rf_pkg::*;
#(
  parameter int NCPUS     = 4,
  parameter int CPU_IDX_W = 2,
  parameter int TGT_W     = 8
) (
  input  logic [NCPUS-1:0]  cpu_any,
  input  logic [DATA_W-1:0] m_pend,
  input  logic [DATA_W-1:0] mask,
  input  logic [TGT_W-1:0]  tgt,
  output logic [NCPUS-1:0]  irq
);

  logic                 m_req;
  logic [CPU_IDX_W-1:0] tgt_eff;
  logic [DATA_W-1:0]    en_bits;

  always_comb begin
    en_bits = {1'b0, mask[GLOBAL_EN_BIT-1:0]};
    m_req   = mask[GLOBAL_EN_BIT] & (|(m_pend & en_bits));
    tgt_eff = (tgt < TGT_W'(NCPUS)) ? tgt[CPU_IDX_W-1:0] : '0;
  end

  for (genvar n = 0; n < NCPUS; n++) begin : g_out
    assign irq[n] = cpu_any[n] | (m_req & (tgt_eff == CPU_IDX_W'(n)));
  end

endmodule

// File: rtl/irq_pending_rf.sv
module irq_pending_rf
  import irq_rf_pkg::*;
#(
  parameter int NCPUS  = 4,
  parameter int ADDR_W = 16,
  parameter int TGT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       dev_irq,
  output logic [NCPUS-1:0]  cpu_irq
);

  localparam int CPU_IDX_W = (NCPUS > 1) ? $clog2(NCPUS) : 1;

  // ---------------- reset release synchroniser ----------------
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // ---------------- address decode ----------------
  reg_sel_e             sel;
  logic [CPU_IDX_W-1:0] cpu_idx;

  irq_rf_decode #(
    .ADDR_W    (ADDR_W),
    .NCPUS     (NCPUS),
    .CPU_IDX_W (CPU_IDX_W)
  ) u_dec (
    .addr    (bus_addr),
    .sel     (sel),
    .cpu_idx (cpu_idx)
  );

  // ---------------- processor banks ----------------
  logic [DATA_W-1:0] cpu_pend [NCPUS];
  logic [DATA_W-1:0] cpu_set  [NCPUS];
  logic [DATA_W-1:0] cpu_clr  [NCPUS];
  logic [NCPUS-1:0]  cpu_any;

  for (genvar n = 0; n < NCPUS; n++) begin : g_cpu
    logic hit;
    assign hit        = bus_wr && (cpu_idx == CPU_IDX_W'(n));
    assign cpu_set[n] = (hit && sel == REG_CPU_SET) ? bus_wdata : '0;
    assign cpu_clr[n] = (hit && sel == REG_CPU_CLR) ? bus_wdata : '0;

    irq_pend_bank #(.W(DATA_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .set_vec (cpu_set[n]),
      .clr_vec (cpu_clr[n]),
      .pend    (cpu_pend[n])
    );

    assign cpu_any[n] = |cpu_pend[n];
  end

  // ---------------- master bank ----------------
  logic [DATA_W-1:0] dev_rise;
  logic [DATA_W-1:0] m_set;
  logic [DATA_W-1:0] m_clr;
  logic [DATA_W-1:0] m_pend;

  irq_dev_edge #(.W(DATA_W)) u_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .lvl   (dev_irq),
    .rise  (dev_rise)
  );

  always_comb begin
    m_set = dev_rise;
    m_clr = '0;
    if (bus_wr && sel == REG_M_SET) m_set = m_set | bus_wdata;
    if (bus_wr && sel == REG_M_CLR) m_clr = bus_wdata;
  end

  irq_pend_bank #(.W(DATA_W)) u_mbank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_vec (m_set),
    .clr_vec (m_clr),
    .pend    (m_pend)
  );

  // ---------------- mask and target registers ----------------
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] mask_d;
  logic              mask_en;
  logic [TGT_W-1:0]  tgt_q;
  logic [TGT_W-1:0]  tgt_d;
  logic              tgt_en;

  always_comb begin
    mask_en = bus_wr && (sel == REG_M_MASK);
    mask_d  = bus_wdata;
    tgt_en  = bus_wr && (sel == REG_M_TGT);
    tgt_d   = bus_wdata[TGT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tgt_q <= '0;
    end else if (tgt_en) begin
      tgt_q <= tgt_d;
    end
  end

  // ---------------- read path ----------------
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    case (sel)
      REG_CPU_PEND: rd_mux = cpu_pend[cpu_idx];
      REG_M_PEND:   rd_mux = m_pend;
      REG_M_MASK:   rd_mux = mask_q;
      REG_M_TGT:    rd_mux = {{(DATA_W-TGT_W){1'b0}}, tgt_q};
      default:      rd_mux = '0;
    endcase
    rdata_d = bus_rd ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

  // ---------------- request steering ----------------
  irq_route #(
    .NCPUS     (NCPUS),
    .CPU_IDX_W (CPU_IDX_W),
    .TGT_W     (TGT_W)
  ) u_route (
    .cpu_any (cpu_any),
    .m_pend  (m_pend),
    .mask    (mask_q),
    .tgt     (tgt_q),
    .irq     (cpu_irq)
  );

endmodule

// File: rtl/irq_pending_rf_chk.sv
module irq_pending_rf_chk #(
  parameter int NCPUS  = 4,
  parameter int ADDR_W = 16,
  parameter int TGT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [31:0]       dev_irq,
  input logic [NCPUS-1:0]  cpu_irq,
  input logic [NCPUS-1:0]  cpu_any,
  input logic [31:0]       m_pend,
  input logic [31:0]       mask,
  input logic [TGT_W-1:0]  tgt
);

  localparam int PG_W      = ADDR_W - 12;
  localparam int CPU_IDX_W = (NCPUS > 1) ? $clog2(NCPUS) : 1;

  logic [PG_W-1:0]      a_pg;
  logic [11:0]          a_off;
  logic [CPU_IDX_W-1:0] a_idx;
  logic                 a_readable;
  logic                 a_cpu_set;

  always_comb begin
    a_pg       = bus_addr[ADDR_W-1:12];
    a_off      = bus_addr[11:0];
    a_idx      = a_pg[CPU_IDX_W-1:0];
    a_readable = ((a_pg < PG_W'(NCPUS)) && a_off == 12'h000) ||
                 ((a_pg == PG_W'(NCPUS)) &&
                  (a_off == 12'h000 || a_off == 12'h004 || a_off == 12'h010));
    a_cpu_set  = bus_wr && (a_pg < PG_W'(NCPUS)) && a_off == 12'h008 && bus_wdata != 32'h0;
  end

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == 32'h0); // R2

  AST_UNREADABLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !a_readable) |=> bus_rdata == 32'h0); // R7

  AST_CPU_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    a_cpu_set |=> cpu_irq[$past(a_idx)]); // R3

  AST_BANK_DRIVES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_any & ~cpu_irq) == '0); // R8

  AST_GLOBAL_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask[31] && cpu_any == '0) |-> cpu_irq == '0); // R9

  AST_TARGET_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mask[31] && (|(m_pend[30:0] & mask[30:0])) && tgt >= TGT_W'(NCPUS)) |-> cpu_irq[0]); // R10

  for (genvar i = 0; i < 32; i++) begin : g_rise
    // a rise sets its bit even against a same-edge clear (R5)
    AST_DEV_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_irq[i] && !$past(dev_irq[i])) |=> m_pend[i]); // R11
  end

endmodule

bind irq_pending_rf irq_pending_rf_chk #(
  .NCPUS  (NCPUS),
  .ADDR_W (ADDR_W),
  .TGT_W  (TGT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .dev_irq   (dev_irq),
  .cpu_irq   (cpu_irq),
  .cpu_any   (cpu_any),
  .m_pend    (m_pend),
  .mask      (mask_q),
  .tgt       (tgt_q)
);

// File: tb/tb_irq_pending_rf.sv
`timescale 1ns/1ps
module tb_irq_pending_rf;

  localparam int NCPUS  = 4;
  localparam int ADDR_W = 16;
  localparam int TGT_W  = 8;
  localparam int MB     = NCPUS * 4096;

  logic              clk;
  logic              rst_n;
  logic              bus_wr;
  logic              bus_rd;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic [31:0]       dev_irq;
  logic [NCPUS-1:0]  cpu_irq;

  int n_checks = 0;
  int n_fail   = 0;

  irq_pending_rf #(.NCPUS(NCPUS), .ADDR_W(ADDR_W), .TGT_W(TGT_W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .dev_irq   (dev_irq),
    .cpu_irq   (cpu_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_cpu [NCPUS];
  logic [31:0] m_mp, m_mask, m_prev, m_rd;
  logic [7:0]  m_tgt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCPUS; i++) m_cpu[i] = 32'h0;
      m_mp = 0; m_mask = 0; m_prev = 0; m_rd = 0; m_tgt = 0;
    end else begin : step
      int pg, off;
      logic [31:0] rv, sv, cv, rise;
      pg  = int'(bus_addr) / 4096;
      off = int'(bus_addr) % 4096;
      rv  = 32'h0;
      if (bus_rd) begin
        if (pg < NCPUS && off == 0) rv = m_cpu[pg];
        else if (pg == NCPUS) begin
          if (off == 0)  rv = m_mp;
          if (off == 4)  rv = m_mask;
          if (off == 16) rv = {24'h0, m_tgt};
        end
      end
      m_rd   = rv;
      rise   = dev_irq & ~m_prev;
      m_prev = dev_irq;
      sv = rise;
      cv = 32'h0;
      if (bus_wr) begin
        if (pg < NCPUS) begin
          if (off == 4) m_cpu[pg] = m_cpu[pg] & ~bus_wdata;
          if (off == 8) m_cpu[pg] = m_cpu[pg] | bus_wdata;
        end else if (pg == NCPUS) begin
          if (off == 4)  m_mask = bus_wdata;
          if (off == 8)  cv = bus_wdata;
          if (off == 12) sv = sv | bus_wdata;
          if (off == 16) m_tgt = bus_wdata[7:0];
        end
      end
      m_mp = (m_mp & ~cv) | sv;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin : cmp
      logic [NCPUS-1:0] exp_irq;
      int t;
      t = (int'(m_tgt) < NCPUS) ? int'(m_tgt) : 0;
      for (int n = 0; n < NCPUS; n++)
        exp_irq[n] = (m_cpu[n] != 0) ||
                     (m_mask[31] && ((m_mp & m_mask & 32'h7fff_ffff) != 0) && t == n);
      check("R8/R9 cpu_irq per clock", 32'(cpu_irq), 32'(exp_irq));
      check("R2 rdata per clock", bus_rdata, m_rd);
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 32'h0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    check(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] bank_val [NCPUS];
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = 0; dev_irq = 0;
    repeat (3) @(negedge clk);
    check("R1 reset cpu_irq", 32'(cpu_irq), 32'h0);
    check("R1 reset rdata", bus_rdata, 32'h0);
    rst_n = 1'b1;
    idle(5);
    rd(MB + 16, 32'h0, "R1 target after reset");
    rd(MB + 4,  32'h0, "R1 mask after reset");
    rd(MB + 0,  32'h0, "R1 master pending after reset");

    // processor banks: set, layout, irq
    for (int n = 0; n < NCPUS; n++) begin
      bank_val[n] = 32'hA5A5_0000 | (32'h1 << n);
      wr(n * 4096 + 8, bank_val[n]);
      check("R8 cpu_irq after set", 32'(cpu_irq), (32'h1 << (n + 1)) - 1);
      rd(n * 4096, bank_val[n], "R3 set then R2 read of bank");
    end
    wr(4096 + 8, 32'h0);
    rd(4096, bank_val[1], "R3 zero set bits keep value");
    wr(4096 + 4, 32'h00A5_0002);
    rd(4096, 32'hA500_0000, "R4 clear only ones");
    wr(4096 + 4, 32'h0);
    rd(4096, 32'hA500_0000, "R4 zero clear bits keep value");

    // write-only and unmapped
    rd(4,            32'h0, "R7 clear word reads zero");
    rd(8,            32'h0, "R7 set word reads zero");
    rd(12,           32'h0, "R7 unmapped cpu offset");
    rd(MB + 8,       32'h0, "R7 master clear reads zero");
    rd(MB + 12,      32'h0, "R7 master set reads zero");
    rd(MB + 20,      32'h0, "R7 unmapped master offset");
    rd(MB + 4096,    32'h0, "R7 page past master");
    wr(4096 + 12, 32'hFFFF_FFFF);
    wr(MB + 4096, 32'hFFFF_FFFF);
    rd(4096, 32'hA500_0000, "R7 unmapped write no effect");
    wr(4096, 32'hFFFF_FFFF);
    rd(4096, 32'hA500_0000, "R7 pending word write no effect");

    for (int n = 0; n < NCPUS; n++) wr(n * 4096 + 4, 32'hFFFF_FFFF);
    check("R8 all banks cleared", 32'(cpu_irq), 32'h0);

    // device edges
    @(negedge clk); dev_irq = 32'h80;
    idle(1);
    rd(MB, 32'h80, "R11 rise sets master bit");
    wr(MB + 8, 32'h80);
    rd(MB, 32'h0, "R11 held level does not set again");
    @(negedge clk); dev_irq = 32'h0;
    wr(MB + 12, 32'h80);
    rd(MB, 32'h80, "R6 master set word");
    check("R9 no mask no irq", 32'(cpu_irq), 32'h0);

    // mask, global enable, target
    wr(MB + 4, 32'h0000_0080);
    check("R9 global enable off", 32'(cpu_irq), 32'h0);
    wr(MB + 4, 32'h8000_0080);
    check("R9 level 14 enable to cpu0", 32'(cpu_irq), 32'h1);
    rd(MB + 4, 32'h8000_0080, "R6 mask readback");
    wr(MB + 16, 32'h2);
    check("R10 target 2", 32'(cpu_irq), 32'h4);
    rd(MB + 16, 32'h2, "R10 target readback");
    wr(MB + 16, 32'h7);
    check("R10 out of range goes to cpu0", 32'(cpu_irq), 32'h1);
    rd(MB + 16, 32'h7, "R10 out of range readback");
    wr(MB + 16, 32'h3);
    wr(MB + 4, 32'h8008_0000);
    check("R9 bit7 not enabled", 32'(cpu_irq), 32'h0);
    wr(MB + 12, 32'h0008_0000);
    check("R9 level 10 enable to cpu3", 32'(cpu_irq), 32'h8);

    // set beats clear on same edge
    @(negedge clk);
    dev_irq = 32'h8; bus_wr = 1'b1; bus_addr = ADDR_W'(MB + 8); bus_wdata = 32'h88;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 0;
    rd(MB, 32'h0008_0008, "R5 rise wins over clear");
    wr(MB, 32'hFFFF_FFFF);
    rd(MB, 32'h0008_0008, "R7 master pending write no effect");

    // reset in the middle of activity
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R1 reset drops cpu_irq", 32'(cpu_irq), 32'h0);
    dev_irq = 32'h0;
    idle(2);
    rst_n = 1'b1;
    idle(5);
    rd(MB,      32'h0, "R1 master pending cleared");
    rd(MB + 4,  32'h0, "R1 mask cleared");
    rd(MB + 16, 32'h0, "R1 target cleared");

    idle(2);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule